// File: doc/BRIEF.md
# Prescaled 16-bit Event Timer

This block is a 16-bit up-counter that sits behind an 8-bit host register port. Its count source is one of two: an internal tick at one quarter of the system clock, or an external input pin. The external input can pass through a two-stage synchronizer or go straight through. In external mode, a rising edge counts only once a falling edge has been seen since counting was armed. A prescaler follows the source select and divides the source by 1, 2, 4 or 8.

The counter sets a sticky interrupt flag when it wraps. A one-cycle pulse from a capture/compare unit clears the count. Two control bits choose which timer serves as time base for each of two capture/compare channels, and the block exports that choice on two select outputs. A 16-bit access mode places a buffer in front of the high byte, so that software can read or write the whole count in a single coherent access.

The host port has four addresses: 0 is control, 1 is the low count byte, 2 is the high count byte, and 3 is the flag. Writes take effect on the clock edge where `bus_wr` is high. `bus_rdata` is combinational from `bus_addr` and the current state.

Top module: `ptimer16`

## Requirements
- R1: After reset, the control register, both count bytes and the interrupt flag read as zero, `irq` is low, and both channel selects are low.
- R2: With control bit 0 (run) set to 1 and bit 1 (source) set to 0, the count advances from the internal tick. The internal tick comes once every 4 system clocks, counted from reset.
- R3: Control bits [5:4] set the prescale. Codes 00, 01, 10 and 11 need 1, 2, 4 and 8 source ticks per count increment.
- R4: While run is 0, the count holds its value, apart from host writes and the capture/compare clear.
- R5: With source set to 1, the count advances on rising edges of `ext_clk_in`. Edges count only after a falling edge has been seen since run and source were both last set. A rising edge already present when counting is armed is therefore ignored.
- R6: With source set to 1, control bit 2 selects the external path. A value of 0 passes `ext_clk_in` through a two-flop synchronizer. A value of 1 bypasses the synchronizer. The bit has no effect on counting while source is 0.
- R7: A wrap from FFFFh to 0000h sets the flag (address 3, bit 0) and drives `irq`. The flag stays set until the host writes address 3, which loads bit 0 of the write data into the flag. A wrap in the same cycle takes priority over that write.
- R8: A high `ccp_clear` on a clock edge sets the count to 0000h, unless a count-byte write happens in the same cycle.
- R9: `cc1_this_timer` equals control bit 6. `cc2_this_timer` equals control bit 6 OR control bit 3.
- R10: With control bit 7 (wide mode) set to 1, a read of address 1 copies the live high byte into a buffer. Reads of address 2 then return that buffer.
- R11: In wide mode, a write to address 2 loads only the buffer. A following write to address 1 loads the whole count as {buffer, data}.
- R12: With wide mode at 0, addresses 1 and 2 read and write the live low and high bytes on their own. Any count-byte write clears the prescaler phase and leaves the prescale setting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 count low, 2 count high, 3 flag |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used for the wide-mode high-byte capture |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| ext_clk_in | input | 1 | External count input |
| ccp_clear | input | 1 | Count clear pulse from a capture/compare unit |
| irq | output | 1 | Sticky wrap flag |
| cc1_this_timer | output | 1 | Channel 1 uses this timer as time base |
| cc2_this_timer | output | 1 | Channel 2 uses this timer as time base |

## Verification
The embedded properties assume that `bus_wr` and `bus_rd` are single-cycle strobes with a stable address, and that `ccp_clear` is a clean synchronous pulse. They also assume the external input is sampled only by the system clock, so no rising edge is seen on two consecutive cycles. The stimulus drives every input on the falling clock edge and holds each external level for at least one full cycle. It raises strobes for exactly one cycle and keeps host writes away from the cycles it uses to judge hold and wrap behaviour. A cycle-accurate behavioural model in the bench follows every clock and is compared with the read data, `irq` and the channel selects.

// File: rtl/ptimer16_pkg.sv
package ptimer16_pkg;

  localparam int PS_W = 2;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CLO  = 2'd1,
    REG_CHI  = 2'd2,
    REG_FLAG = 2'd3
  } reg_sel_e;

  // Field order is fixed by the host view of the control byte.
  typedef struct packed {
    logic            wide;     // 16-bit coherent access
    logic            src_hi;   // time base select, upper bit
    logic [PS_W-1:0] ps;       // prescale code
    logic            src_lo;   // time base select, lower bit
    logic            nosync;   // bypass external synchronizer
    logic            ext_sel;  // 1 = external input
    logic            run;      // count enable
  } ctrl_t;

endpackage

// File: rtl/ptm_int_div.sv
module ptm_int_div #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic int_tick
);
  logic [DIV_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 1'b1;
  end

  assign int_tick = &phase_q;

  // R2
  int_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_tick |=> !int_tick);
endmodule

// File: rtl/ptm_ext_qual.sv
module ptm_ext_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic bypass,
  input  logic active,
  output logic ext_tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic armed_q;
  logic level;
  logic rise_evt;
  logic fall_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= ext_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign level    = bypass ? ext_in : sync_q[SYNC_STAGES-1];
  assign rise_evt = level & ~prev_q;
  assign fall_evt = ~level & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= level;
      if (!active)       armed_q <= 1'b0;
      else if (fall_evt) armed_q <= 1'b1;
    end
  end

  assign ext_tick = active & armed_q & rise_evt;

  // R5
  ext_no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick);
  // R5
  ext_armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !ext_tick);
endmodule

// File: rtl/ptm_prescale.sv
module ptm_prescale #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick_in,
  input  logic [CODE_W-1:0] code,
  output logic              tick_out
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  function automatic logic [CNT_W-1:0] div_limit(input logic [CODE_W-1:0] c);
    div_limit = CNT_W'((32'd1 << c) - 32'd1);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = cnt_q >= div_limit(code);
  assign tick_out = tick_in & ~clear & at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (tick_in) cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end

  // R3
  presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> cnt_q == '0);
  // R12
  presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0);
endmodule

// File: rtl/ptimer16.sv
module ptimer16
  import ptimer16_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int INT_DIV_W   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              ext_clk_in,
  input  logic              ccp_clear,
  output logic              irq,
  output logic              cc1_this_timer,
  output logic              cc2_this_timer
);
  localparam int CNT_W = 2 * BYTE_W;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    bump = v + 1'b1;
  endfunction

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    at_top = &v;
  endfunction

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   count_q;
  logic [BYTE_W-1:0]  hbuf_q;
  logic               flag_q;

  logic ctl_wr, lo_wr, hi_wr, flg_wr, lo_rd;
  logic cnt_load;
  logic int_tick, ext_tick, src_tick, presc_tick;
  logic wrap_evt;

  assign ctl_wr   = bus_wr && (bus_addr == REG_CTRL);
  assign lo_wr    = bus_wr && (bus_addr == REG_CLO);
  assign hi_wr    = bus_wr && (bus_addr == REG_CHI);
  assign flg_wr   = bus_wr && (bus_addr == REG_FLAG);
  assign lo_rd    = bus_rd && (bus_addr == REG_CLO);
  assign cnt_load = lo_wr | hi_wr;

  ptm_int_div #(.DIV_W(INT_DIV_W)) u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_tick (int_tick)
  );

  ptm_ext_qual #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_in   (ext_clk_in),
    .bypass   (ctrl_q.nosync),
    .active   (ctrl_q.run & ctrl_q.ext_sel),
    .ext_tick (ext_tick)
  );

  assign src_tick = ctrl_q.run & (ctrl_q.ext_sel ? ext_tick : int_tick);

  ptm_prescale #(.CODE_W(PS_W)) u_ps (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_load),
    .tick_in  (src_tick),
    .code     (ctrl_q.ps),
    .tick_out (presc_tick)
  );

  assign wrap_evt = presc_tick & ~ccp_clear & at_top(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctl_wr) ctrl_q <= ctrl_t'(bus_wdata[7:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (lo_wr) begin
      count_q <= ctrl_q.wide ? {hbuf_q, bus_wdata}
                             : {count_q[CNT_W-1:BYTE_W], bus_wdata};
    end else if (hi_wr && !ctrl_q.wide) begin
      count_q <= {bus_wdata, count_q[BYTE_W-1:0]};
    end else if (ccp_clear) begin
      count_q <= '0;
    end else if (presc_tick) begin
      count_q <= bump(count_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hbuf_q <= '0;
    else if (ctrl_q.wide && hi_wr) hbuf_q <= bus_wdata;
    else if (ctrl_q.wide && lo_rd) hbuf_q <= count_q[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap_evt) flag_q <= 1'b1;
    else if (flg_wr)   flag_q <= bus_wdata[0];
  end

  always_comb begin
    unique case (bus_addr)
      REG_CTRL: bus_rdata = BYTE_W'(ctrl_q);
      REG_CLO:  bus_rdata = count_q[BYTE_W-1:0];
      REG_CHI:  bus_rdata = ctrl_q.wide ? hbuf_q : count_q[CNT_W-1:BYTE_W];
      default:  bus_rdata = BYTE_W'(flag_q);
    endcase
  end

  assign irq            = flag_q;
  assign cc1_this_timer = ctrl_q.src_hi;
  assign cc2_this_timer = ctrl_q.src_hi | ctrl_q.src_lo;

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> irq);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !flg_wr |=> irq);
  // R8
  ccp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ccp_clear && !cnt_load |=> count_q == '0);
  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run && !cnt_load && !ccp_clear |=> $stable(count_q));
  // R9
  sel_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc1_this_timer |-> cc2_this_timer);
  // R11
  wide_hi_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.wide && hi_wr && !ccp_clear && !presc_tick |=> $stable(count_q));
endmodule

// File: tb/ptimer16_tb.sv
`timescale 1ns/1ps
module ptimer16_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ext_clk_in = 1'b0;
  logic       ccp_clear = 1'b0;
  logic       irq, cc1_this_timer, cc2_this_timer;

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  ptimer16 u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_in(ext_clk_in), .ccp_clear(ccp_clear), .irq(irq),
    .cc1_this_timer(cc1_this_timer), .cc2_this_timer(cc2_this_timer)
  );

  // Behavioural reference model
  bit [7:0]  m_ctrl;
  bit [15:0] m_cnt;
  bit [7:0]  m_hb;
  bit        m_flag, m_prev, m_armed;
  int        m_pc, m_n;
  bit        xh[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_hb = 0; m_flag = 0; m_prev = 0; m_armed = 0;
      m_pc = 0; m_n = 0; xh = {1'b0, 1'b0};
    end else begin
      bit on, cs, nb, wide, cur, rise, fall, tin, pt, wrap;
      int div;
      bit [15:0] old;
      on = m_ctrl[0]; cs = m_ctrl[1]; nb = m_ctrl[2]; wide = m_ctrl[7];
      div = 1 << m_ctrl[5:4];
      old = m_cnt;
      cur = nb ? ext_clk_in : xh[1];
      rise = cur && !m_prev;
      fall = !cur && m_prev;
      tin = on && (cs ? (rise && m_armed) : ((m_n % 4) == 3));
      pt = 0;
      if (bus_wr && (bus_addr == 1 || bus_addr == 2)) m_pc = 0;
      else if (tin) begin
        if (m_pc >= div - 1) begin m_pc = 0; pt = 1; end
        else m_pc = m_pc + 1;
      end
      wrap = 0;
      if (bus_wr && bus_addr == 1) m_cnt = wide ? {m_hb, bus_wdata} : {old[15:8], bus_wdata};
      else if (bus_wr && bus_addr == 2 && !wide) m_cnt = {bus_wdata, old[7:0]};
      else if (ccp_clear) m_cnt = 0;
      else if (pt) begin wrap = (old == 16'hFFFF); m_cnt = old + 16'd1; end
      if (wide && bus_wr && bus_addr == 2) m_hb = bus_wdata;
      else if (wide && bus_rd && bus_addr == 1) m_hb = old[15:8];
      if (wrap) m_flag = 1;
      else if (bus_wr && bus_addr == 3) m_flag = bus_wdata[0];
      if (bus_wr && bus_addr == 0) m_ctrl = bus_wdata;
      if (!(on && cs)) m_armed = 0;
      else if (fall) m_armed = 1;
      m_prev = cur;
      m_n = m_n + 1;
      xh.push_front(ext_clk_in);
      void'(xh.pop_back());
    end
  end

  function automatic bit [7:0] m_rdata();
    case (bus_addr)
      2'd0: return m_ctrl;
      2'd1: return m_cnt[7:0];
      2'd2: return m_ctrl[7] ? m_hb : m_cnt[15:8];
      default: return {7'd0, m_flag};
    endcase
  endfunction

  task automatic check(string t, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
    end
  endtask

  task automatic check_range(string t, int got, int lo, int hi);
    n_checks++;
    if (got < lo || got > hi) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d..%0d", t, got, lo, hi);
    end
  endtask

  // Per-cycle comparison against the model
  always begin
    @(posedge clk);
    #2;
    if (rst_n && !done) begin
      check({tag, " rdata"}, bus_rdata, m_rdata());
      check({tag, " irq R7"}, irq, m_flag);
      check({tag, " sel R9"}, {cc1_this_timer, cc2_this_timer},
            {m_ctrl[6], m_ctrl[6] | m_ctrl[3]});
    end
  end

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_addr = 2'd1;
  endtask

  task automatic rd(input bit [1:0] a, output bit [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_addr = 2'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk_in = 0; idle(2);
      @(negedge clk); ext_clk_in = 1; idle(2);
    end
    idle(6);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    bit [7:0] d, d2;
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(1);
    tag = "R1";
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); check("R1 reset reg", d, 0); end
    check("R1 irq", irq, 0);
    check("R1 sel", {cc1_this_timer, cc2_this_timer}, 0);

    tag = "R2";
    wr(0, 8'h01); idle(40); wr(0, 8'h00);
    rd(1, d); check_range("R2 internal rate", d, 9, 11);
    tag = "R4";
    idle(20); rd(1, d2); check("R4 hold while stopped", d2, d);

    tag = "R3";
    wr(2, 0); wr(1, 0); wr(0, 8'h31); idle(64); wr(0, 8'h00);
    rd(1, d); check_range("R3 prescale 1:8", d, 1, 3);
    wr(1, 0); wr(0, 8'h11); idle(40); wr(0, 8'h00);
    rd(1, d); check_range("R3 prescale 1:2", d, 4, 6);
    wr(1, 0); wr(0, 8'h21); idle(40); wr(0, 8'h00);
    rd(1, d); check_range("R3 prescale 1:4", d, 2, 3);

    tag = "R12";
    wr(0, 8'h21); idle(5); wr(1, 8'h40); idle(7); wr(2, 8'h12); idle(9); wr(0, 8'h00);
    rd(2, d); check("R12 live high byte", d, 8'h12);

    tag = "R6";
    wr(1, 0); wr(0, 8'h05); idle(40); wr(0, 8'h00);
    rd(1, d); check_range("R6 sync bit ignored internally", d, 9, 11);

    tag = "R5";
    ext_clk_in = 1; wr(1, 0); wr(0, 8'h07); pulses(4); wr(0, 8'h00);
    rd(1, d); check("R5 edges from high start", d, 4);
    @(negedge clk); ext_clk_in = 0;
    wr(1, 0); wr(0, 8'h07); idle(2);
    @(negedge clk); ext_clk_in = 1; idle(3);
    pulses(3); wr(0, 8'h00);
    rd(1, d); check("R5 first rise ignored", d, 3);

    tag = "R6";
    ext_clk_in = 1; wr(1, 0); wr(0, 8'h03); pulses(5); wr(0, 8'h00);
    rd(1, d); check("R6 synchronized path", d, 5);

    tag = "R7";
    wr(2, 8'hFF); wr(1, 8'hFC); wr(0, 8'h01); idle(30); wr(0, 8'h00);
    check("R7 wrap sets irq", irq, 1);
    rd(2, d); check("R7 count wrapped", d, 0);
    idle(10); check("R7 flag sticky", irq, 1);
    wr(3, 8'h00); idle(1); check("R7 flag cleared", irq, 0);

    tag = "R8";
    wr(1, 8'h55); wr(2, 8'h66);
    @(negedge clk); ccp_clear = 1; @(negedge clk); ccp_clear = 0;
    rd(1, d); check("R8 clear low", d, 0);
    rd(2, d); check("R8 clear high", d, 0);
    wr(0, 8'h01); idle(9);
    @(negedge clk); ccp_clear = 1; @(negedge clk); ccp_clear = 0;
    idle(6); wr(0, 8'h00);

    tag = "R9";
    wr(0, 8'h08); check("R9 code 01", {cc1_this_timer, cc2_this_timer}, 2'b01);
    wr(0, 8'h40); check("R9 code 10", {cc1_this_timer, cc2_this_timer}, 2'b11);
    wr(0, 8'h48); check("R9 code 11", {cc1_this_timer, cc2_this_timer}, 2'b11);
    wr(0, 8'h00); check("R9 code 00", {cc1_this_timer, cc2_this_timer}, 2'b00);

    tag = "R10";
    wr(2, 8'h12); wr(1, 8'h34); wr(0, 8'h80);
    rd(1, d); check("R10 wide low read", d, 8'h34);
    rd(2, d); check("R10 buffered high", d, 8'h12);
    tag = "R11";
    wr(2, 8'hAB); rd(2, d); check("R11 buffer only", d, 8'hAB);
    rd(1, d); check("R11 low unchanged", d, 8'h34);
    wr(2, 8'hCD); wr(1, 8'hEF); wr(0, 8'h00);
    rd(2, d); check("R11 paired write high", d, 8'hCD);
    rd(1, d); check("R11 paired write low", d, 8'hEF);

    tag = "R10";
    wr(0, 8'h81); idle(3);
    for (int i = 0; i < 6; i++) begin rd(1, d); idle(i); rd(2, d2); idle(2); end
    wr(0, 8'h00);
    idle(4);
    finish_run();
  end
endmodule